// File: doc/BRIEF.md
# ISA-Style Memory Cycle Master

This block turns one-at-a-time internal read and write requests into memory cycles on a 16-bit ISA-style bus. A request carries an address, a write word, two byte enables and a flag saying the addressed target is only 8 bits wide. The request is taken only while the block is idle. When every bus cycle for the request has finished, the block answers with a one-clock done pulse and, for a read, the assembled word.

Each bus cycle has the same shape. The address is driven for one clock of setup. A read or write strobe is then held low for a fixed number of clocks. One idle recovery clock follows. The block also drives a second pair of strobes that follow the main ones only while the address lies in the lowest megabyte. The data bus is modelled as separate in, out and output-enable signals.

For a narrow target, the block moves every byte on data lanes 7:0. A full-word request becomes two byte cycles, and a byte bound for the upper lanes is moved down to the lower lanes.

Top module: `isa_mem_master`

## Requirements
- R1: While reset is held and after it is released, both main strobes and both low-megabyte strobes are high, the data output enable is low and done is low.
- R2: When tgt_8bit is 0 at acceptance, the request makes one word cycle on the even address (req_addr with bit 0 cleared), and req_be is ignored. A write drives all 16 lanes with req_wdata. A read returns bus_d_in as captured.
- R3: bus_addr holds its cycle value for the whole clock before a strobe falls. It stays stable while the strobe is low.
- R4: Each strobe stays low for exactly STROBE_CLKS clocks (default 2). Read data is sampled on the clock edge that ends the last low clock. One recovery clock with both strobes high follows before the next setup clock. A single-cycle request raises done 4 clocks after the accepting edge, and a two-cycle request raises it 8 clocks after.
- R5: A read cycle drives bus_memr_n low and a write cycle drives bus_memw_n low, whatever the address. The two are never low together.
- R6: bus_smemr_n and bus_smemw_n are low only while their main strobe is low and bus_addr bits ADDR_W-1 down to 20 are all zero. In that case they are always low.
- R7: When tgt_8bit is 1 and req_be is 2'b11 or 2'b00, the request makes two byte cycles. The first is at the even address and carries the low byte. The second is at the even address plus one and carries the high byte moved down to lanes 7:0. Lanes 15:8 are driven to zero. A read puts the first byte in rd_data[7:0] and the second in rd_data[15:8].
- R8: When tgt_8bit is 1 and req_be is 2'b01, the request makes one byte cycle at the even address with the low byte. When req_be is 2'b10, it makes one byte cycle at the odd address with the high byte on lanes 7:0. A read with 2'b10 returns the byte in rd_data[15:8] and zero in rd_data[7:0].
- R9: bus_d_oe is high only for write requests. It rises with the setup clock and falls one clock after the final write strobe is released. It stays high between the two byte cycles of a split write, and it is low during read cycles.
- R10: done is high for exactly one clock, in the clock after the final recovery clock. A req_valid raised while a request is in progress is ignored and starts no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Write word |
| req_be | input | 2 | Byte enables, low byte in bit 0 |
| tgt_8bit | input | 1 | Target is 8 bits wide, sampled with the request |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | DATA_W | Assembled read word, valid with done |
| bus_addr | output | ADDR_W | Bus address lines |
| bus_d_in | input | DATA_W | Data bus as received |
| bus_d_out | output | DATA_W | Data bus as driven |
| bus_d_oe | output | 1 | Data bus output enable |
| bus_memr_n | output | 1 | Memory read strobe, active low |
| bus_memw_n | output | 1 | Memory write strobe, active low |
| bus_smemr_n | output | 1 | Low-megabyte read strobe, active low |
| bus_smemw_n | output | 1 | Low-megabyte write strobe, active low |

## Verification
The requests are full words to a wide target, split words to a narrow target (enables 11 and 00), and single bytes with enable 01 or 10. Each pattern is tried as a read and as a write, so a wrong address bit 0, a missing or extra byte cycle, and a lane fault (unsteered, swapped or not zeroed) each give a different bus record. The narrow-target model drives the unused upper lanes with a filler byte, and any clock other than the last strobe clock returns a poison word. A sample taken on the wrong clock, or taken from the wrong lanes, therefore shows in rd_data. Addresses are placed on both sides of the one-megabyte line to separate the two strobe pairs, and a request held high while the block is busy shows whether it is ignored.

// File: rtl/isa_mem_pkg.sv
package isa_mem_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_RECOVER
  } seq_state_t;

  // Which lanes a bus cycle uses
  typedef enum logic [1:0] {
    PH_WORD,   // all lanes, wide target
    PH_LO,     // low byte, even address
    PH_HI      // high byte moved to lanes 7:0, odd address
  } lane_phase_t;

endpackage

// File: rtl/isa_byte_plan.sv
module isa_byte_plan
  import isa_mem_pkg::*;
(
  input  logic        narrow,
  input  logic [1:0]  be,
  output lane_phase_t first_phase,
  output logic        two_beats
);

  always_comb begin
    first_phase = PH_WORD;
    two_beats   = 1'b0;
    if (narrow) begin
      case (be)
        2'b01:   first_phase = PH_LO;
        2'b10:   first_phase = PH_HI;
        default: begin
          first_phase = PH_LO;
          two_beats   = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/isa_lane_steer.sv
module isa_lane_steer
  import isa_mem_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  lane_phase_t       wr_phase,
  input  logic [DATA_W-1:0] wdata,
  input  lane_phase_t       rd_phase,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] rd_acc,
  output logic [DATA_W-1:0] dout_next,
  output logic [DATA_W-1:0] rd_next
);

  localparam int BYTE_W = DATA_W / 2;

  always_comb begin
    case (wr_phase)
      PH_LO:   dout_next = {{BYTE_W{1'b0}}, wdata[BYTE_W-1:0]};
      PH_HI:   dout_next = {{BYTE_W{1'b0}}, wdata[DATA_W-1:BYTE_W]};
      default: dout_next = wdata;
    endcase
  end

  always_comb begin
    case (rd_phase)
      PH_LO:   rd_next = {rd_acc[DATA_W-1:BYTE_W], din[BYTE_W-1:0]};
      PH_HI:   rd_next = {din[BYTE_W-1:0], rd_acc[BYTE_W-1:0]};
      default: rd_next = din;
    endcase
  end

endmodule

// File: rtl/isa_strobe_gen.sv
module isa_strobe_gen #(
  parameter int ADDR_W = 24,
  parameter int LOW_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_d,
  input  logic              wr_d,
  input  logic [ADDR_W-1:0] addr,
  output logic              memr_n,
  output logic              memw_n,
  output logic              smemr_n,
  output logic              smemw_n
);

  logic in_low;
  assign in_low = (addr[ADDR_W-1:LOW_W] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      memr_n  <= 1'b1;
      memw_n  <= 1'b1;
      smemr_n <= 1'b1;
      smemw_n <= 1'b1;
    end else begin
      memr_n  <= !(strobe_d && !wr_d);
      memw_n  <= !(strobe_d && wr_d);
      smemr_n <= !(strobe_d && !wr_d && in_low);
      smemw_n <= !(strobe_d && wr_d && in_low);
    end
  end

endmodule

// File: rtl/isa_cycle_seq.sv
module isa_cycle_seq
  import isa_mem_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 16,
  parameter int STROBE_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  lane_phase_t       first_phase,
  input  logic              two_beats,
  input  logic [DATA_W-1:0] dout_next,
  input  logic [DATA_W-1:0] rd_next,
  output lane_phase_t       steer_wr_phase,
  output logic [DATA_W-1:0] steer_wdata,
  output lane_phase_t       cur_phase,
  output logic              strobe_d,
  output logic              wr,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dout,
  output logic              oe,
  output logic              done,
  output logic [DATA_W-1:0] rd_data
);

  localparam int CNT_W = (STROBE_CLKS > 1) ? $clog2(STROBE_CLKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STROBE_CLKS - 1);

  seq_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic              second_pend;
  logic [DATA_W-1:0] wdata_q;
  logic [ADDR_W-1:0] base_q;
  logic              accept;

  assign accept = (state == ST_IDLE) && req_valid;

  always_comb begin
    steer_wr_phase = accept ? first_phase : PH_HI;
    steer_wdata    = accept ? req_wdata : wdata_q;
    strobe_d       = (state == ST_SETUP) ||
                     ((state == ST_STROBE) && (cnt != LAST));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      second_pend <= 1'b0;
      wdata_q     <= '0;
      base_q      <= '0;
      cur_phase   <= PH_WORD;
      wr          <= 1'b0;
      addr        <= '0;
      dout        <= '0;
      oe          <= 1'b0;
      done        <= 1'b0;
      rd_data     <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            wr          <= req_write;
            wdata_q     <= req_wdata;
            base_q      <= {req_addr[ADDR_W-1:1], 1'b0};
            cur_phase   <= first_phase;
            second_pend <= two_beats;
            addr        <= {req_addr[ADDR_W-1:1], (first_phase == PH_HI)};
            dout        <= dout_next;
            oe          <= req_write;
            rd_data     <= '0;
            state       <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          cnt   <= '0;
          state <= ST_STROBE;
        end
        ST_STROBE: begin
          if (cnt == LAST) begin
            if (!wr) rd_data <= rd_next;
            state <= ST_RECOVER;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: begin
          if (second_pend) begin
            second_pend <= 1'b0;
            cur_phase   <= PH_HI;
            addr        <= {base_q[ADDR_W-1:1], 1'b1};
            dout        <= dout_next;
            state       <= ST_SETUP;
          end else begin
            oe    <= 1'b0;
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/isa_mem_master.sv
module isa_mem_master
  import isa_mem_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 16,
  parameter int LOW_W       = 20,
  parameter int STROBE_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  input  logic              tgt_8bit,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_d_in,
  output logic [DATA_W-1:0] bus_d_out,
  output logic              bus_d_oe,
  output logic              bus_memr_n,
  output logic              bus_memw_n,
  output logic              bus_smemr_n,
  output logic              bus_smemw_n
);

  lane_phase_t       first_phase;
  logic              two_beats;
  lane_phase_t       steer_wr_phase;
  lane_phase_t       cur_phase;
  logic [DATA_W-1:0] steer_wdata;
  logic [DATA_W-1:0] dout_next;
  logic [DATA_W-1:0] rd_next;
  logic              strobe_d;
  logic              wr;

  isa_byte_plan u_plan (
    .narrow      (tgt_8bit),
    .be          (req_be),
    .first_phase (first_phase),
    .two_beats   (two_beats)
  );

  isa_lane_steer #(.DATA_W(DATA_W)) u_steer (
    .wr_phase  (steer_wr_phase),
    .wdata     (steer_wdata),
    .rd_phase  (cur_phase),
    .din       (bus_d_in),
    .rd_acc    (rd_data),
    .dout_next (dout_next),
    .rd_next   (rd_next)
  );

  isa_cycle_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STROBE_CLKS(STROBE_CLKS)
  ) u_seq (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .req_addr       (req_addr),
    .req_wdata      (req_wdata),
    .first_phase    (first_phase),
    .two_beats      (two_beats),
    .dout_next      (dout_next),
    .rd_next        (rd_next),
    .steer_wr_phase (steer_wr_phase),
    .steer_wdata    (steer_wdata),
    .cur_phase      (cur_phase),
    .strobe_d       (strobe_d),
    .wr             (wr),
    .addr           (bus_addr),
    .dout           (bus_d_out),
    .oe             (bus_d_oe),
    .done           (done),
    .rd_data        (rd_data)
  );

  isa_strobe_gen #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_strobe (
    .clk      (clk),
    .rst      (rst),
    .strobe_d (strobe_d),
    .wr_d     (wr),
    .addr     (bus_addr),
    .memr_n   (bus_memr_n),
    .memw_n   (bus_memw_n),
    .smemr_n  (bus_smemr_n),
    .smemw_n  (bus_smemw_n)
  );

endmodule

// File: rtl/isa_mem_master_chk.sv
module isa_mem_master_chk #(
  parameter int ADDR_W      = 24,
  parameter int LOW_W       = 20,
  parameter int STROBE_CLKS = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_d_oe,
  input logic              bus_memr_n,
  input logic              bus_memw_n,
  input logic              bus_smemr_n,
  input logic              bus_smemw_n
);

  logic       act;
  logic       low_addr;
  logic [7:0] run;

  assign act      = !bus_memr_n || !bus_memw_n;
  assign low_addr = (bus_addr[ADDR_W-1:LOW_W] == '0);

  always_ff @(posedge clk) begin
    if (rst)      run <= '0;
    else if (act) run <= run + 8'd1;
    else          run <= '0;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (bus_memr_n && bus_memw_n && bus_smemr_n && bus_smemw_n && !bus_d_oe && !done));

  p_addr_setup_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(act) |-> $stable(bus_addr));

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (act && $past(act)) |-> $stable(bus_addr));

  p_strobe_len_r4: assert property (@(posedge clk) disable iff (rst)
    (!act && run != 8'd0) |-> (run == 8'(STROBE_CLKS)));

  p_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(!bus_memr_n && !bus_memw_n));

  p_smemr_sub_r6: assert property (@(posedge clk) disable iff (rst)
    !bus_smemr_n |-> (!bus_memr_n && low_addr));

  p_smemw_sub_r6: assert property (@(posedge clk) disable iff (rst)
    !bus_smemw_n |-> (!bus_memw_n && low_addr));

  p_smem_cover_r6: assert property (@(posedge clk) disable iff (rst)
    low_addr |-> ((bus_memr_n == bus_smemr_n) && (bus_memw_n == bus_smemw_n)));

  p_oe_write_r9: assert property (@(posedge clk) disable iff (rst)
    !bus_memw_n |-> bus_d_oe);

  p_oe_read_r9: assert property (@(posedge clk) disable iff (rst)
    !bus_memr_n |-> !bus_d_oe);

  p_oe_tail_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_memw_n) |-> bus_d_oe);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> (bus_memr_n && bus_memw_n));

endmodule

bind isa_mem_master isa_mem_master_chk #(
  .ADDR_W(ADDR_W), .LOW_W(LOW_W), .STROBE_CLKS(STROBE_CLKS)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .done        (done),
  .bus_addr    (bus_addr),
  .bus_d_oe    (bus_d_oe),
  .bus_memr_n  (bus_memr_n),
  .bus_memw_n  (bus_memw_n),
  .bus_smemr_n (bus_smemr_n),
  .bus_smemw_n (bus_smemw_n)
);

// File: tb/isa_mem_master_tb.sv
`timescale 1ns/1ps
module isa_mem_master_tb;

  localparam int AW = 24;
  localparam int DW = 16;
  localparam int SC = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0]    req_be = 2'b11;
  logic          tgt_8bit = 1'b0;
  logic          done;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_d_in;
  logic [DW-1:0] bus_d_out;
  logic          bus_d_oe;
  logic          bus_memr_n, bus_memw_n, bus_smemr_n, bus_smemw_n;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  isa_mem_master u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .tgt_8bit(tgt_8bit), .done(done), .rd_data(rd_data),
    .bus_addr(bus_addr), .bus_d_in(bus_d_in), .bus_d_out(bus_d_out),
    .bus_d_oe(bus_d_oe), .bus_memr_n(bus_memr_n), .bus_memw_n(bus_memw_n),
    .bus_smemr_n(bus_smemr_n), .bus_smemw_n(bus_smemw_n)
  );

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5C;
  endfunction

  // Bus target model: valid data only on the last strobe clock
  int low_cnt = 0;
  always_comb begin
    if (low_cnt == SC)
      bus_d_in = tgt_8bit ? {8'hEE, pat(bus_addr)}
                          : {pat({bus_addr[AW-1:1], 1'b1}), pat(bus_addr)};
    else
      bus_d_in = 16'hDEAD;
  end

  // Bus monitor
  logic [AW-1:0] log_addr [0:3];
  logic [DW-1:0] log_dout [0:3];
  logic          log_wr [0:3];
  logic          log_smem [0:3];
  logic          log_setup [0:3];
  logic          log_oe [0:3];
  logic          log_oe_setup [0:3];
  logic          log_oe_after [0:3];
  int            log_len [0:3];
  int            log_n = 0;
  logic          prev_act = 1'b0;
  logic          prev_oe = 1'b0;
  logic [AW-1:0] prev_addr = '0;

  always @(negedge clk) begin
    logic act;
    act = !bus_memr_n || !bus_memw_n;
    if (act && !prev_act && log_n < 4) begin
      log_addr[log_n]     = bus_addr;
      log_dout[log_n]     = bus_d_out;
      log_wr[log_n]       = !bus_memw_n;
      log_smem[log_n]     = !bus_memw_n ? !bus_smemw_n : !bus_smemr_n;
      log_setup[log_n]    = (bus_addr == prev_addr);
      log_oe[log_n]       = bus_d_oe;
      log_oe_setup[log_n] = prev_oe;
    end
    if (!act && prev_act) begin
      if (log_n < 4) begin
        log_len[log_n]      = low_cnt;
        log_oe_after[log_n] = bus_d_oe;
      end
      log_n = log_n + 1;
    end
    low_cnt   = act ? low_cnt + 1 : 0;
    prev_act  = act;
    prev_oe   = bus_d_oe;
    prev_addr = bus_addr;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act_v,
                     input logic [31:0] exp_v);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  // Issue one request, wait for done; returns edges to done and read word
  task automatic run_req(input logic wr_i, input logic [AW-1:0] a,
                         input logic [DW-1:0] wd, input logic [1:0] be,
                         input logic narrow, input bit spam,
                         output int lat, output logic [DW-1:0] rd);
    int cyc;
    @(negedge clk);
    log_n     = 0;
    req_write = wr_i; req_addr = a; req_wdata = wd; req_be = be;
    tgt_8bit  = narrow; req_valid = 1'b1;
    @(negedge clk);
    req_valid = spam;
    if (spam) req_addr = a ^ 24'h000F00;
    cyc = 1;
    while (!done && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    lat = cyc - 1;
    rd  = rd_data;
    chk(done == 1'b1, "R10 done seen", {31'd0, done}, 32'd1);
    chk(bus_d_oe == 1'b0, "R9 oe low at done", {31'd0, bus_d_oe}, 32'd0);
    @(negedge clk);
    chk(done == 1'b0, "R10 done one clock", {31'd0, done}, 32'd0);
  endtask

  // Check one logged bus cycle
  task automatic chk_cyc(input int i, input logic [AW-1:0] a, input logic wr_i,
                         input logic [DW-1:0] d, input logic smem);
    chk(log_addr[i] == a, "R2/R7/R8 cycle address", 32'(log_addr[i]), 32'(a));
    chk(log_wr[i] == wr_i, "R5 strobe type", {31'd0, log_wr[i]}, {31'd0, wr_i});
    chk(log_setup[i], "R3 address setup", {31'd0, log_setup[i]}, 32'd1);
    chk(log_len[i] == SC, "R4 strobe width", 32'(log_len[i]), 32'(SC));
    chk(log_smem[i] == smem, "R6 low-megabyte strobe", {31'd0, log_smem[i]}, {31'd0, smem});
    if (wr_i) begin
      chk(log_dout[i] == d, "R2/R7/R8 write lanes", {16'd0, log_dout[i]}, {16'd0, d});
      chk(log_oe[i] && log_oe_setup[i] && log_oe_after[i], "R9 oe window on write",
          {29'd0, log_oe_setup[i], log_oe[i], log_oe_after[i]}, 32'd7);
    end else begin
      chk(!log_oe[i] && !log_oe_after[i], "R9 oe low on read",
          {30'd0, log_oe[i], log_oe_after[i]}, 32'd0);
    end
  endtask

  task automatic t_reset;
    chk(bus_memr_n && bus_memw_n && bus_smemr_n && bus_smemw_n, "R1 strobes idle",
        {28'd0, bus_memr_n, bus_memw_n, bus_smemr_n, bus_smemw_n}, 32'hF);
    chk(!bus_d_oe && !done, "R1 oe and done low", {30'd0, bus_d_oe, done}, 32'd0);
  endtask

  task automatic t_word_write;
    int lat; logic [DW-1:0] rd;
    run_req(1'b1, 24'h001235, 16'hBEEF, 2'b01, 1'b0, 1'b0, lat, rd);
    chk(log_n == 1, "R2 one word cycle", 32'(log_n), 32'd1);
    chk(lat == 4, "R4 word latency", 32'(lat), 32'd4);
    chk_cyc(0, 24'h001234, 1'b1, 16'hBEEF, 1'b1);
  endtask

  task automatic t_word_read;
    int lat; logic [DW-1:0] rd;
    run_req(1'b0, 24'h3A0041, 16'h0000, 2'b11, 1'b0, 1'b0, lat, rd);
    chk(log_n == 1, "R2 one word cycle", 32'(log_n), 32'd1);
    chk_cyc(0, 24'h3A0040, 1'b0, 16'h0, 1'b0);
    chk(rd == {pat(24'h3A0041), pat(24'h3A0040)}, "R2/R4 word read data",
        {16'd0, rd}, {16'd0, pat(24'h3A0041), pat(24'h3A0040)});
  endtask

  task automatic t_split_write;
    int lat; logic [DW-1:0] rd;
    run_req(1'b1, 24'h002000, 16'hA55A, 2'b11, 1'b1, 1'b0, lat, rd);
    chk(log_n == 2, "R7 two byte cycles", 32'(log_n), 32'd2);
    chk(lat == 8, "R4 split latency", 32'(lat), 32'd8);
    chk_cyc(0, 24'h002000, 1'b1, 16'h005A, 1'b1);
    chk_cyc(1, 24'h002001, 1'b1, 16'h00A5, 1'b1);
  endtask

  task automatic t_split_read;
    int lat; logic [DW-1:0] rd;
    run_req(1'b0, 24'h100010, 16'h0000, 2'b00, 1'b1, 1'b0, lat, rd);
    chk(log_n == 2, "R7 two byte cycles (be 00)", 32'(log_n), 32'd2);
    chk_cyc(0, 24'h100010, 1'b0, 16'h0, 1'b0);
    chk_cyc(1, 24'h100011, 1'b0, 16'h0, 1'b0);
    chk(rd == {pat(24'h100011), pat(24'h100010)}, "R7 split read assembly",
        {16'd0, rd}, {16'd0, pat(24'h100011), pat(24'h100010)});
  endtask

  task automatic t_byte_ops;
    int lat; logic [DW-1:0] rd;
    run_req(1'b0, 24'h000301, 16'h0000, 2'b10, 1'b1, 1'b0, lat, rd);
    chk(log_n == 1, "R8 one byte cycle", 32'(log_n), 32'd1);
    chk_cyc(0, 24'h000301, 1'b0, 16'h0, 1'b1);
    chk(rd == {pat(24'h000301), 8'h00}, "R8 high byte read",
        {16'd0, rd}, {16'd0, pat(24'h000301), 8'h00});
    run_req(1'b1, 24'h000500, 16'h1234, 2'b01, 1'b1, 1'b0, lat, rd);
    chk(log_n == 1, "R8 one byte cycle", 32'(log_n), 32'd1);
    chk_cyc(0, 24'h000500, 1'b1, 16'h0034, 1'b1);
    run_req(1'b1, 24'h000500, 16'h1234, 2'b10, 1'b1, 1'b0, lat, rd);
    chk(log_n == 1, "R8 one byte cycle", 32'(log_n), 32'd1);
    chk_cyc(0, 24'h000501, 1'b1, 16'h0012, 1'b1);
  endtask

  task automatic t_busy_ignore;
    int lat; logic [DW-1:0] rd;
    run_req(1'b1, 24'h004000, 16'h0F0F, 2'b11, 1'b0, 1'b1, lat, rd);
    chk(log_n == 1, "R10 busy request ignored", 32'(log_n), 32'd1);
    chk(log_addr[0] == 24'h004000, "R10 original address kept",
        32'(log_addr[0]), 32'h004000);
    repeat (8) @(negedge clk);
    chk(log_n == 1 && bus_memr_n && bus_memw_n, "R10 no cycle after done",
        32'(log_n), 32'd1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_word_write();
    t_word_read();
    t_split_write();
    t_split_read();
    t_byte_ops();
    t_busy_ignore();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL R10 watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
    end
  end

endmodule